// File: doc/BRIEF.md
# Banked Fail-Information Cache

This block is a small direct-mapped cache for a resistive-memory write path. It does not hold user data. Each entry records one defective cell of a recently written memory block: the bit position of the stuck cell inside the block, and the value that cell is stuck at. Before a block is written, the write path looks up its block address. On a hit it already knows the fault, so it can choose the group inversion flags before the first write. The verify-and-rewrite round trip is then avoided.

The storage is split into banks, and the low bits of the block address pick the bank. A lookup enables only the bank it addresses. Inside that bank, the next address bits pick one set, and the remaining upper bits are compared against the stored tag. The lookup result is returned one cycle after the request. A fill port writes an entry after a verify has found a fault. An invalidate port drops the entry an address maps to. Tag, pointer and stuck value sit in synchronous-read arrays suited to block RAM. The valid bits are kept in flops, so that reset empties the whole cache.

Top module: `fail_info_cache`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses until a fill is made.
- R2: `lk_vld` is high in exactly the cycle after a cycle with `lk_req` high, and low otherwise.
- R3: With the default parameters, the address fields are as follows. Bank = `addr[3:0]`, set = `addr[9:4]`, tag = `addr[32:10]`. A lookup hits only if the entry at that bank and set is valid and its stored tag equals the address tag.
- R4: On a hit, `lk_ptr` and `lk_stuck` equal the pointer and stuck value of the most recent fill to that entry.
- R5: Whenever `lk_hit` is low, `lk_ptr` is zero and `lk_stuck` is 0.
- R6: A fill to an occupied entry overwrites it. Afterwards the new address hits with the new data, and the previous address misses.
- R7: An invalidate clears the valid bit of the entry its address maps to, whatever tag is stored there. Later lookups of that entry miss.
- R8: When a fill and an invalidate hit the same entry in the same cycle, the entry ends up invalid.
- R9: A lookup and a fill to the same entry in the same cycle return the contents from before the fill. The fill is seen by the next lookup.
- R10: A lookup and an invalidate to the same entry in the same cycle return the contents from before the invalidate.
- R11: Entries whose addresses differ only in their bank or set bits are held independently. Filling or invalidating one leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Block address to look up |
| fill_en | input | 1 | Write an entry |
| fill_addr | input | ADDR_W | Block address of the entry to write |
| fill_ptr | input | PTR_W | Bit position of the stuck cell |
| fill_stuck | input | 1 | Value the cell is stuck at |
| inv_en | input | 1 | Invalidate an entry |
| inv_addr | input | ADDR_W | Block address whose entry is dropped |
| lk_vld | output | 1 | Lookup result valid, one cycle after `lk_req` |
| lk_hit | output | 1 | Lookup hit |
| lk_ptr | output | PTR_W | Stored fault bit position, zero on miss |
| lk_stuck | output | 1 | Stored stuck value, zero on miss |

## Verification
A valid bit held in the wrong state appears on the next lookup of that entry. A valid bit left set after reset or invalidate shows up as a false `lk_hit`. A fill that did not take shows up as a miss. A field decoded from the wrong address bits, or a write sent to the wrong bank, corrupts a neighbouring entry. That error becomes visible when the neighbour is next looked up, which in the mixed random phase is usually within a few tens of cycles. Same-cycle collisions are driven on purpose, so a write-first read or a fill that beats invalidate is seen in the very next `lk_vld` cycle.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int DEF_ADDR_W  = 33;
  localparam int DEF_ENTRIES = 1024;
  localparam int DEF_BANKS   = 16;
  localparam int DEF_PTR_W   = 9;
endpackage

// File: rtl/fic_bank.sv
module fic_bank #(
  parameter int SET_W = 6,
  parameter int TAG_W = 23,
  parameter int PTR_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [SET_W-1:0] rd_set,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic             wr_stuck,
  input  logic             clr_en,
  input  logic [SET_W-1:0] clr_set,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             rd_stuck
);
  localparam int SETS = 1 << SET_W;
  localparam int DW   = TAG_W + PTR_W + 1;

  logic [DW-1:0]   mem [SETS];
  logic [DW-1:0]   rd_word;
  logic [SETS-1:0] valid;

  // data array: one write port, one read-first read port
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_set] <= {wr_tag, wr_ptr, wr_stuck};
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_word <= mem[rd_set];
  end

  assign {rd_tag, rd_ptr, rd_stuck} = rd_word;

  // valid bits in flops so reset clears the whole bank; clear beats set
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
    end else begin
      if (wr_en)  valid[wr_set]  <= 1'b1;
      if (clr_en) valid[clr_set] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_valid <= 1'b0;
    else if (rd_en) rd_valid <= valid[rd_set];
  end

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !valid[$past(clr_set)]);

  assert_fill_marks_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(clr_en && clr_set == wr_set)) |=> valid[$past(wr_set)]);
endmodule

// File: rtl/fic_match.sv
module fic_match #(
  parameter int NUM_BANKS = 16,
  parameter int TAG_W     = 23,
  parameter int PTR_W     = 9,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             lk_req,
  input  logic [BANK_W-1:0]                lk_bank,
  input  logic [TAG_W-1:0]                 lk_tag,
  input  logic [NUM_BANKS-1:0]             bk_valid,
  input  logic [NUM_BANKS-1:0][TAG_W-1:0]  bk_tag,
  input  logic [NUM_BANKS-1:0][PTR_W-1:0]  bk_ptr,
  input  logic [NUM_BANKS-1:0]             bk_stuck,
  output logic                             lk_vld,
  output logic                             lk_hit,
  output logic [PTR_W-1:0]                 lk_ptr,
  output logic                             lk_stuck
);
  logic              req_q;
  logic [BANK_W-1:0] bank_q;
  logic [TAG_W-1:0]  tag_q;
  logic              hit;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= lk_req;
  end

  always_ff @(posedge clk) begin
    if (lk_req) begin
      bank_q <= lk_bank;
      tag_q  <= lk_tag;
    end
  end

  always_comb begin
    hit = req_q && bk_valid[bank_q] && (bk_tag[bank_q] == tag_q);
  end

  assign lk_vld   = req_q;
  assign lk_hit   = hit;
  assign lk_ptr   = hit ? bk_ptr[bank_q] : '0;
  assign lk_stuck = hit & bk_stuck[bank_q];
endmodule

// File: rtl/fail_info_cache.sv
module fail_info_cache
  import fic_pkg::*;
#(
  parameter int ADDR_W    = DEF_ADDR_W,
  parameter int ENTRIES   = DEF_ENTRIES,
  parameter int NUM_BANKS = DEF_BANKS,
  parameter int PTR_W     = DEF_PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_req,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [PTR_W-1:0]  fill_ptr,
  input  logic              fill_stuck,
  input  logic              inv_en,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              lk_vld,
  output logic              lk_hit,
  output logic [PTR_W-1:0]  lk_ptr,
  output logic              lk_stuck
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int SET_W  = $clog2(ENTRIES / NUM_BANKS);
  localparam int IDX_W  = BANK_W + SET_W;
  localparam int TAG_W  = ADDR_W - IDX_W;

  logic [BANK_W-1:0] lk_bank, fill_bank, inv_bank;
  logic [SET_W-1:0]  lk_set, fill_set, inv_set;
  logic [TAG_W-1:0]  lk_tag, fill_tag;

  assign lk_bank   = lk_addr[BANK_W-1:0];
  assign lk_set    = lk_addr[BANK_W +: SET_W];
  assign lk_tag    = lk_addr[ADDR_W-1:IDX_W];
  assign fill_bank = fill_addr[BANK_W-1:0];
  assign fill_set  = fill_addr[BANK_W +: SET_W];
  assign fill_tag  = fill_addr[ADDR_W-1:IDX_W];
  assign inv_bank  = inv_addr[BANK_W-1:0];
  assign inv_set   = inv_addr[BANK_W +: SET_W];

  logic [NUM_BANKS-1:0]            bk_valid;
  logic [NUM_BANKS-1:0][TAG_W-1:0] bk_tag;
  logic [NUM_BANKS-1:0][PTR_W-1:0] bk_ptr;
  logic [NUM_BANKS-1:0]            bk_stuck;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    fic_bank #(.SET_W(SET_W), .TAG_W(TAG_W), .PTR_W(PTR_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .rd_en    (lk_req  && lk_bank   == BANK_W'(b)),
      .rd_set   (lk_set),
      .wr_en    (fill_en && fill_bank == BANK_W'(b)),
      .wr_set   (fill_set),
      .wr_tag   (fill_tag),
      .wr_ptr   (fill_ptr),
      .wr_stuck (fill_stuck),
      .clr_en   (inv_en  && inv_bank  == BANK_W'(b)),
      .clr_set  (inv_set),
      .rd_valid (bk_valid[b]),
      .rd_tag   (bk_tag[b]),
      .rd_ptr   (bk_ptr[b]),
      .rd_stuck (bk_stuck[b])
    );
  end

  fic_match #(.NUM_BANKS(NUM_BANKS), .TAG_W(TAG_W), .PTR_W(PTR_W)) u_match (
    .clk      (clk),
    .rst      (rst),
    .lk_req   (lk_req),
    .lk_bank  (lk_bank),
    .lk_tag   (lk_tag),
    .bk_valid (bk_valid),
    .bk_tag   (bk_tag),
    .bk_ptr   (bk_ptr),
    .bk_stuck (bk_stuck),
    .lk_vld   (lk_vld),
    .lk_hit   (lk_hit),
    .lk_ptr   (lk_ptr),
    .lk_stuck (lk_stuck)
  );

  assert_vld_after_req_R2: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_vld);
  assert_vld_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !lk_vld);
  assert_hit_in_slot_R3: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_vld);
  assert_miss_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_ptr == '0 && !lk_stuck));
endmodule

// File: tb/tb_fail_info_cache.sv
module tb_fail_info_cache;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 33;
  localparam int PW = 9;

  logic clk = 1'b0;
  logic rst;
  logic lk_req, fill_en, fill_stuck, inv_en;
  logic [AW-1:0] lk_addr, fill_addr, inv_addr;
  logic [PW-1:0] fill_ptr;
  logic lk_vld, lk_hit, lk_stuck;
  logic [PW-1:0] lk_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  fail_info_cache dut (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_addr(lk_addr),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_ptr(fill_ptr),
    .fill_stuck(fill_stuck), .inv_en(inv_en), .inv_addr(inv_addr),
    .lk_vld(lk_vld), .lk_hit(lk_hit), .lk_ptr(lk_ptr), .lk_stuck(lk_stuck)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic          m_val [1024];
  logic [22:0]   m_tag [1024];
  logic [PW-1:0] m_ptr [1024];
  logic          m_stk [1024];

  function automatic int idx_of(logic [AW-1:0] a);
    return int'(a[9:0]);
  endfunction

  function automatic logic exp_hit(logic [AW-1:0] a);
    return m_val[idx_of(a)] && (m_tag[idx_of(a)] == a[32:10]);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, update model, check at following negedge
  task automatic step(string req, logic lk, logic [AW-1:0] la,
                      logic fe, logic [AW-1:0] fa, logic [PW-1:0] fp, logic fs,
                      logic ie, logic [AW-1:0] ia);
    logic          eh;
    logic [PW-1:0] ep;
    logic          es;
    lk_req = lk; lk_addr = la;
    fill_en = fe; fill_addr = fa; fill_ptr = fp; fill_stuck = fs;
    inv_en = ie; inv_addr = ia;
    eh = lk && exp_hit(la);
    ep = eh ? m_ptr[idx_of(la)] : '0;
    es = eh ? m_stk[idx_of(la)] : 1'b0;
    if (fe) begin
      m_val[idx_of(fa)] = 1'b1; m_tag[idx_of(fa)] = fa[32:10];
      m_ptr[idx_of(fa)] = fp;   m_stk[idx_of(fa)] = fs;
    end
    if (ie) m_val[idx_of(ia)] = 1'b0;
    @(negedge clk);
    check("R2", 32'(lk_vld), 32'(lk));
    check(req, 32'(lk_hit), 32'(eh));
    if (eh) check("R4", 32'({lk_ptr, lk_stuck}), 32'({ep, es}));
    else    check("R5", 32'({lk_ptr, lk_stuck}), 32'({ep, es}));
  endtask

  task automatic look(string req, logic [AW-1:0] a);
    step(req, 1'b1, a, 1'b0, '0, '0, 1'b0, 1'b0, '0);
  endtask

  task automatic fill(logic [AW-1:0] a, logic [PW-1:0] p, logic s);
    step("R4", 1'b0, '0, 1'b1, a, p, s, 1'b0, '0);
  endtask

  task automatic inval(logic [AW-1:0] a);
    step("R7", 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b1, a);
  endtask

  function automatic logic [AW-1:0] mk(int tag, int set, int bank);
    return {23'(tag), 6'(set), 4'(bank)};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a, b;
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) begin
      m_val[i] = 1'b0; m_tag[i] = '0; m_ptr[i] = '0; m_stk[i] = 1'b0;
    end
    rst = 1'b1; lk_req = 0; lk_addr = '0; fill_en = 0; fill_addr = '0;
    fill_ptr = '0; fill_stuck = 0; inv_en = 0; inv_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", 32'(lk_vld), 32'd0);

    // R1: empty after reset
    look("R1", mk(0, 0, 0));
    look("R1", mk(5, 17, 9));
    // R2: idle cycle
    step("R2", 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0, '0);

    // R3/R4 basic hit and tag mismatch
    a = mk(23'h1abcd, 12, 3);
    fill(a, 9'd301, 1'b1);
    look("R3", a);
    look("R3", mk(23'h1abce, 12, 3));
    // R11 neighbours in other bank / set
    look("R11", mk(23'h1abcd, 12, 4));
    fill(mk(23'h1abcd, 12, 4), 9'd7, 1'b0);
    fill(mk(23'h1abcd, 13, 3), 9'd8, 1'b1);
    look("R11", a);
    look("R11", mk(23'h1abcd, 12, 4));
    look("R11", mk(23'h1abcd, 13, 3));

    // R6 overwrite
    b = mk(23'h00042, 12, 3);
    fill(b, 9'd511, 1'b0);
    look("R6", b);
    look("R6", a);

    // R7 invalidate with a different tag at same index
    inval(mk(23'h7ffff, 12, 3));
    look("R7", b);
    look("R11", mk(23'h1abcd, 12, 4));

    // R8 fill and invalidate same entry together
    a = mk(23'h00077, 40, 15);
    step("R8", 1'b0, '0, 1'b1, a, 9'd100, 1'b1, 1'b1, a);
    look("R8", a);

    // R9 lookup with fill same entry
    a = mk(23'h00011, 5, 6);
    fill(a, 9'd33, 1'b0);
    step("R9", 1'b1, a, 1'b1, a, 9'd44, 1'b1, 1'b0, '0);
    look("R9", a);
    b = mk(23'h00099, 6, 6);
    step("R9", 1'b1, b, 1'b1, b, 9'd55, 1'b0, 1'b0, '0);
    look("R9", b);

    // R10 lookup with invalidate same entry
    step("R10", 1'b1, a, 1'b0, '0, '0, 1'b0, 1'b1, a);
    look("R10", a);

    // random phase over a small address pool
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] ra, fa, ia;
      ra = mk(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
      fa = mk(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
      ia = mk(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
      step("R3", ($urandom_range(0, 3) != 0), ra,
           ($urandom_range(0, 2) == 0), fa, PW'($urandom), 1'($urandom),
           ($urandom_range(0, 7) == 0), ia);
    end

    // R1 again: reset empties a populated cache
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 1024; i++) m_val[i] = 1'b0;
    look("R1", mk(0, 0, 0));
    look("R1", mk(1, 1, 1));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule